// File: doc/BRIEF.md
# ADC power and calibration sequencer

This block is the control engine that sits behind an ADC enable and calibration register. It turns register-level settings into a power sequence for the converter: power-up, standby entry, and a fixed recovery wait on the way out of standby. It also schedules self-calibration cycles and reports status. A calibration can be asked for in three ways: automatically after power-up, by a software request, or by a periodic timer that runs from a 32 kHz tick. A calibration is not launched as soon as it is asked for. It waits until the converter has gone a programmable number of consecutive clocks with no activity. Completion comes back from the calibration engine as a one-cycle done pulse.

The same block keeps the test-enable bit and its set-only lock. Once the lock is set, test enable can still be cleared but can no longer be set. The analog converter, the calibration algorithm, trigger routing and the result path all live outside this block.

Top module: `adc_pwrcal_seq`

## Requirements
- R1: After reset, mode_o = 00 and every other output is 0.
- R2: When enable_i rises, pwr_en_o goes high at once. mode_o stays 00 for exactly PWRUP_CYCLES clocks, then reads 10 (fully on).
- R3: ready_o is 1 only in the on state and only once the first calibration after power-up has completed. It is 0 while off, powering up, in standby or waking.
- R4: A pending calibration (initial, software or periodic) launches when the run of activity-free clocks reaches the length that idle_sel_i selects: 0 = 2, 1 = 4, 2 = 8, 3 = 16. cal_start_o then pulses that many clocks after the request becomes pending.
- R5: A clock with conv_busy_i = 1 resets the activity-free run to zero, so no launch can occur in the next cycle.
- R6: A pulse on cal_req_set_i sets cal_req_o, which hardware clears in the cycle after the launch. A pulse while enable_i = 0 is ignored.
- R7: cal_ready_o reads 0 from the launch until cal_done_i arrives and reads 1 afterwards.
- R8: The periodic timer raises a request every TICKS_PER_SEC ticks times 1, 64, 1024 or 4096, for cal_rate_i = 0, 1, 2 or 3.
- R9: No periodic request is made while auto_cal_en_i = 0.
- R10: Software and periodic requests that are pending at the same time produce a single calibration.
- R11: While standby_i = 1 and no calibration is running, the block is in standby: mode_o = 01 and stby_o = 1. After standby_i falls, mode_o stays 01 for exactly WAKE_CYCLES clocks (230 by default), then reads 10.
- R12: When enable_i = 0, the next cycle shows mode 00 with ready_o, cal_ready_o, cal_req_o and pwr_en_o all 0. Any pending request is dropped.
- R13: A write of 1 to test enable takes effect only while the lock is 0. A write of 0 always clears test enable.
- R14: A pulse on test_lock_set_i sets test_lock_o, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ADC clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Module enable |
| standby_i | input | 1 | Standby request |
| cal_req_set_i | input | 1 | Software calibration request pulse |
| auto_cal_en_i | input | 1 | Periodic recalibration enable |
| cal_rate_i | input | 2 | Recalibration period select |
| idle_sel_i | input | 2 | Activity-free run length select |
| test_en_wr_i | input | 1 | Test-enable write strobe |
| test_en_wdata_i | input | 1 | Test-enable write data |
| test_lock_set_i | input | 1 | Lock set pulse |
| tick_32k_i | input | 1 | Slow oscillator tick |
| conv_busy_i | input | 1 | Converter activity this cycle |
| cal_done_i | input | 1 | Calibration finished pulse |
| pwr_en_o | output | 1 | Analog power enable |
| stby_o | output | 1 | Reduced-power standby |
| cal_start_o | output | 1 | Calibration launch pulse |
| cal_req_o | output | 1 | Software request pending |
| cal_ready_o | output | 1 | Calibration finished flag |
| ready_o | output | 1 | ADC ready |
| mode_o | output | 2 | 00 down, 01 standby, 10 on |
| test_en_o | output | 1 | Test mode enable |
| test_lock_o | output | 1 | Test-enable lock |

## Verification
The bench pulses activity at chosen offsets inside the idle wait, for every run length. A gate that did not restart its count on activity would launch early, and one that counted an extra clock would launch late. It measures the exact interval between periodic launches at all four rates, so a prescaler that is off by one shows up at once. It counts the power-up and wake-up windows clock by clock, holds a software and a periodic request pending together to catch a double calibration, and disables the block mid-request to catch requests that survive power-down. It also writes test enable around the lock to catch a lock that blocks clearing or can itself be cleared.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    PS_OFF, PS_PWRUP, PS_ON, PS_STBY, PS_WAKE
  } pwr_state_e;

  function automatic logic [4:0] idle_len(input logic [1:0] sel);
    return 5'd2 << sel;
  endfunction

  function automatic logic [12:0] period_sec(input logic [1:0] rate);
    case (rate)
      2'd0:    return 13'd1;
      2'd1:    return 13'd64;
      2'd2:    return 13'd1024;
      default: return 13'd4096;
    endcase
  endfunction
endpackage

// File: rtl/adc_recal_timer.sv
module adc_recal_timer #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [1:0] rate_i,
  output logic       due_o
);
  import adc_seq_pkg::*;

  localparam int TW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_SEC - 1);

  logic [TW-1:0] tick_cnt_q;
  logic [12:0]   sec_cnt_q;
  logic          sec_wrap;

  assign sec_wrap = tick_i && (tick_cnt_q == TICK_LAST);
  assign due_o    = run_i && sec_wrap && (sec_cnt_q >= period_sec(rate_i) - 13'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt_q <= '0;
      sec_cnt_q  <= '0;
    end else if (!run_i) begin
      tick_cnt_q <= '0;
      sec_cnt_q  <= '0;
    end else if (tick_i) begin
      if (sec_wrap) begin
        tick_cnt_q <= '0;
        sec_cnt_q  <= due_o ? 13'd0 : sec_cnt_q + 13'd1;
      end else begin
        tick_cnt_q <= tick_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_idle_gate.sv
module adc_idle_gate (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       act_i,
  input  logic [1:0] sel_i,
  output logic       fire_o
);
  import adc_seq_pkg::*;

  logic [4:0] run_q;
  logic [4:0] len;

  assign len    = idle_len(sel_i);
  assign fire_o = arm_i && (run_q >= len);

  // run of activity-free clocks, counted only while a request waits
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 run_q <= '0;
    else if (!arm_i || act_i)    run_q <= '0;
    else if (run_q < len)        run_q <= run_q + 5'd1;
  end
endmodule

// File: rtl/adc_test_lock.sv
module adc_test_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_i,
  input  logic lock_set_i,
  output logic test_en_o,
  output logic lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_en_o <= 1'b0;
      lock_o    <= 1'b0;
    end else begin
      if (lock_set_i) lock_o <= 1'b1;
      if (wr_i) begin
        if (!wdata_i)     test_en_o <= 1'b0;
        else if (!lock_o) test_en_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm #(
  parameter int PWRUP_CYCLES = 32,
  parameter int WAKE_CYCLES  = 230
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    enable_i,
  input  logic                    standby_i,
  input  logic                    hold_i,
  output adc_seq_pkg::pwr_state_e state_o
);
  import adc_seq_pkg::*;

  localparam int MAXC = (PWRUP_CYCLES > WAKE_CYCLES) ? PWRUP_CYCLES : WAKE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PWRUP_LAST = CW'(PWRUP_CYCLES - 1);
  localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYCLES - 1);

  pwr_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_OFF;
      cnt_q   <= '0;
    end else if (!enable_i) begin
      state_q <= PS_OFF;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        PS_OFF: begin
          state_q <= PS_PWRUP;
          cnt_q   <= '0;
        end
        PS_PWRUP: begin
          if (cnt_q == PWRUP_LAST) state_q <= PS_ON;
          else                     cnt_q   <= cnt_q + 1'b1;
        end
        PS_ON: begin
          // never drop into standby under a running calibration
          if (standby_i && !hold_i) state_q <= PS_STBY;
        end
        PS_STBY: begin
          if (!standby_i) begin
            state_q <= PS_WAKE;
            cnt_q   <= '0;
          end
        end
        PS_WAKE: begin
          if (cnt_q == WAKE_LAST) state_q <= PS_ON;
          else                    cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= PS_OFF;
      endcase
    end
  end
endmodule

// File: rtl/adc_pwrcal_seq.sv
module adc_pwrcal_seq #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int PWRUP_CYCLES  = 32,
  parameter int WAKE_CYCLES   = 230
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       standby_i,
  input  logic       cal_req_set_i,
  input  logic       auto_cal_en_i,
  input  logic [1:0] cal_rate_i,
  input  logic [1:0] idle_sel_i,
  input  logic       test_en_wr_i,
  input  logic       test_en_wdata_i,
  input  logic       test_lock_set_i,
  input  logic       tick_32k_i,
  input  logic       conv_busy_i,
  input  logic       cal_done_i,
  output logic       pwr_en_o,
  output logic       stby_o,
  output logic       cal_start_o,
  output logic       cal_req_o,
  output logic       cal_ready_o,
  output logic       ready_o,
  output logic [1:0] mode_o,
  output logic       test_en_o,
  output logic       test_lock_o
);
  import adc_seq_pkg::*;

  pwr_state_e state;
  logic off, on, due, launch, arm, pend;
  logic sw_req_q, per_req_q, cal_busy_q, cal_rdy_q, init_done_q;

  assign off  = !enable_i || (state == PS_OFF);
  assign on   = (state == PS_ON);
  assign pend = sw_req_q || per_req_q || !init_done_q;
  assign arm  = on && !cal_busy_q && pend;

  adc_pwr_fsm #(
    .PWRUP_CYCLES(PWRUP_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .standby_i(standby_i),
    .hold_i   (cal_busy_q || launch),
    .state_o  (state)
  );

  adc_recal_timer #(
    .TICKS_PER_SEC(TICKS_PER_SEC)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (auto_cal_en_i && (state != PS_OFF)),
    .tick_i(tick_32k_i),
    .rate_i(cal_rate_i),
    .due_o (due)
  );

  adc_idle_gate u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (arm),
    .act_i (conv_busy_i),
    .sel_i (idle_sel_i),
    .fire_o(launch)
  );

  adc_test_lock u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (test_en_wr_i),
    .wdata_i   (test_en_wdata_i),
    .lock_set_i(test_lock_set_i),
    .test_en_o (test_en_o),
    .lock_o    (test_lock_o)
  );

  // one launch consumes every request pending at that moment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_req_q    <= 1'b0;
      per_req_q   <= 1'b0;
      cal_busy_q  <= 1'b0;
      cal_rdy_q   <= 1'b0;
      init_done_q <= 1'b0;
    end else if (off) begin
      sw_req_q    <= 1'b0;
      per_req_q   <= 1'b0;
      cal_busy_q  <= 1'b0;
      cal_rdy_q   <= 1'b0;
      init_done_q <= 1'b0;
    end else begin
      if (launch) begin
        sw_req_q   <= 1'b0;
        per_req_q  <= 1'b0;
        cal_busy_q <= 1'b1;
        cal_rdy_q  <= 1'b0;
      end else begin
        if (cal_req_set_i) sw_req_q  <= 1'b1;
        if (due)           per_req_q <= 1'b1;
        if (cal_busy_q && cal_done_i) begin
          cal_busy_q  <= 1'b0;
          cal_rdy_q   <= 1'b1;
          init_done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (state)
      PS_ON:            mode_o = 2'b10;
      PS_STBY, PS_WAKE: mode_o = 2'b01;
      default:          mode_o = 2'b00;
    endcase
  end

  assign pwr_en_o    = (state == PS_PWRUP) || on || (state == PS_WAKE);
  assign stby_o      = (state == PS_STBY);
  assign cal_start_o = launch;
  assign cal_req_o   = sw_req_q;
  assign cal_ready_o = cal_rdy_q;
  assign ready_o     = on && init_done_q;
endmodule

// File: rtl/adc_pwrcal_seq_chk.sv
module adc_pwrcal_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       conv_busy_i,
  input logic       pwr_en_o,
  input logic       stby_o,
  input logic       cal_start_o,
  input logic       cal_req_o,
  input logic       cal_ready_o,
  input logic       ready_o,
  input logic [1:0] mode_o,
  input logic       test_en_o,
  input logic       test_lock_o
);
  // R3
  ready_only_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mode_o == 2'b10));

  // R4
  launch_when_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |-> (mode_o == 2'b10 && pwr_en_o));

  // R5
  activity_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_busy_i |=> !cal_start_o);

  // R7
  done_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_start_o |=> !cal_ready_o);

  // R11
  stby_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_o |-> (mode_o == 2'b01 && !ready_o));

  // R12
  disable_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (mode_o == 2'b00 && !ready_o && !cal_req_o && !cal_ready_o && !pwr_en_o));

  // R13
  lock_blocks_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_lock_o && !test_en_o) |=> !test_en_o);

  // R14
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_lock_o |=> test_lock_o);
endmodule

bind adc_pwrcal_seq adc_pwrcal_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .conv_busy_i(conv_busy_i),
  .pwr_en_o   (pwr_en_o),
  .stby_o     (stby_o),
  .cal_start_o(cal_start_o),
  .cal_req_o  (cal_req_o),
  .cal_ready_o(cal_ready_o),
  .ready_o    (ready_o),
  .mode_o     (mode_o),
  .test_en_o  (test_en_o),
  .test_lock_o(test_lock_o)
);

// File: tb/adc_pwrcal_seq_test.sv
`timescale 1ns/1ps
module adc_pwrcal_seq_test;
  localparam int TPS   = 4;
  localparam int PWRUP = 32;
  localparam int WAKE  = 230;

  // idle-gate vectors: select, activity cycle (-1 none), expected launch cycle
  localparam int NV = 8;
  localparam int V_SEL  [NV] = '{0, 1, 2, 3, 0, 1, 2, 3};
  localparam int V_BUSY [NV] = '{-1, -1, -1, -1, 0, 2, 5, 15};
  localparam int V_EXP  [NV] = '{2, 4, 8, 16, 3, 7, 14, 32};
  localparam int RATE_SEC [4] = '{1, 64, 1024, 4096};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enable_i = 0, standby_i = 0, cal_req_set_i = 0, auto_cal_en_i = 0;
  logic [1:0] cal_rate_i = 0, idle_sel_i = 0;
  logic test_en_wr_i = 0, test_en_wdata_i = 0, test_lock_set_i = 0;
  logic tick_32k_i = 0, conv_busy_i = 0, cal_done_i = 0;
  logic pwr_en_o, stby_o, cal_start_o, cal_req_o, cal_ready_o, ready_o;
  logic [1:0] mode_o;
  logic test_en_o, test_lock_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  adc_pwrcal_seq #(
    .TICKS_PER_SEC(TPS), .PWRUP_CYCLES(PWRUP), .WAKE_CYCLES(WAKE)
  ) uut (
    .clk_i, .rst_ni, .enable_i, .standby_i, .cal_req_set_i, .auto_cal_en_i,
    .cal_rate_i, .idle_sel_i, .test_en_wr_i, .test_en_wdata_i, .test_lock_set_i,
    .tick_32k_i, .conv_busy_i, .cal_done_i, .pwr_en_o, .stby_o, .cal_start_o,
    .cal_req_o, .cal_ready_o, .ready_o, .mode_o, .test_en_o, .test_lock_o
  );

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cal_ready();
    for (int k = 0; k < 40 && !cal_ready_o; k++) step();
  endtask

  // calibration engine model: done pulse one cycle after the launch is registered
  initial begin
    forever begin
      @(negedge clk_i);
      if (cal_start_o) begin
        @(negedge clk_i);
        cal_done_i = 1'b1;
        @(negedge clk_i);
        cal_done_i = 1'b0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 ready", ready_o, 0);
    chk("R1 cal_ready", cal_ready_o, 0);
    chk("R1 start", cal_start_o, 0);
    chk("R1 pwr", pwr_en_o, 0);
    chk("R1 test", {test_en_o, test_lock_o}, 0);

    // R6 request ignored while disabled
    cal_req_set_i = 1; step(); cal_req_set_i = 0; step();
    chk("R6 ignored when off", cal_req_o, 0);

    // R2 power-up window
    enable_i = 1;
    n = 0;
    step();
    while (pwr_en_o && mode_o == 2'b00 && n < 1000) begin n++; step(); end
    chk("R2 pwrup cycles", n, PWRUP);
    chk("R2 mode on", mode_o, 2);
    chk("R3 not ready before cal", ready_o, 0);
    wait_cal_ready();
    step();
    chk("R3 ready after first cal", ready_o, 1);
    chk("R7 cal_ready", cal_ready_o, 1);

    // R4 R5 idle-gate table
    for (int i = 0; i < NV; i++) begin
      int got;
      idle_sel_i = V_SEL[i];
      step();
      cal_req_set_i = 1; step(); cal_req_set_i = 0;
      chk("R6 request pending", cal_req_o, 1);
      got = -1;
      for (int j = 0; j < 80; j++) begin
        conv_busy_i = (j == V_BUSY[i]);
        if (cal_start_o) begin got = j; break; end
        step();
      end
      conv_busy_i = 0;
      chk(V_BUSY[i] < 0 ? "R4 launch delay" : "R5 restart delay", got, V_EXP[i]);
      step();
      chk("R6 cleared after launch", cal_req_o, 0);
      chk("R7 in progress", cal_ready_o, 0);
      wait_cal_ready();
      chk("R7 done", cal_ready_o, 1);
    end

    // R9 no periodic launch while disabled
    idle_sel_i = 0; cal_rate_i = 1; tick_32k_i = 1;
    n = 0;
    for (int k = 0; k < 300; k++) begin step(); if (cal_start_o) n++; end
    chk("R9 no periodic", n, 0);

    // R10 coinciding requests
    conv_busy_i = 1; auto_cal_en_i = 1;
    repeat (262) step();
    cal_req_set_i = 1; step(); cal_req_set_i = 0;
    step();
    conv_busy_i = 0;
    n = 0;
    for (int k = 0; k < 40; k++) begin step(); if (cal_start_o) n++; end
    chk("R10 single launch", n, 1);
    chk("R10 request consumed", cal_req_o, 0);
    auto_cal_en_i = 0; step();

    // R8 periodic intervals
    for (int r = 0; r < 4; r++) begin
      cal_rate_i = r[1:0];
      auto_cal_en_i = 1;
      for (int k = 0; k < 20000 && !cal_start_o; k++) step();
      n = 0;
      step(); n++;
      while (!cal_start_o && n < 20000) begin step(); n++; end
      chk("R8 period", n, TPS * RATE_SEC[r]);
      auto_cal_en_i = 0;
      repeat (6) step();
    end
    tick_32k_i = 0;

    // R11 standby and recovery
    chk("R3 ready before standby", ready_o, 1);
    standby_i = 1; step();
    chk("R11 standby mode", mode_o, 1);
    chk("R11 stby", stby_o, 1);
    chk("R3 not ready in standby", ready_o, 0);
    repeat (5) step();
    standby_i = 0;
    n = 0;
    step();
    while (mode_o == 2'b01 && n < 1000) begin n++; step(); end
    chk("R11 wake cycles", n, WAKE);
    chk("R11 back on", mode_o, 2);
    chk("R3 ready after wake", ready_o, 1);

    // R12 disable drops pending work
    conv_busy_i = 1;
    cal_req_set_i = 1; step(); cal_req_set_i = 0;
    chk("R12 pending before", cal_req_o, 1);
    enable_i = 0; step();
    chk("R12 mode", mode_o, 0);
    chk("R12 flags", {ready_o, cal_ready_o, cal_req_o, pwr_en_o}, 0);
    conv_busy_i = 0;

    // R13 R14 test lock
    test_en_wr_i = 1; test_en_wdata_i = 1; step(); test_en_wr_i = 0;
    chk("R13 set unlocked", test_en_o, 1);
    test_lock_set_i = 1; step(); test_lock_set_i = 0; step();
    chk("R14 lock set", test_lock_o, 1);
    chk("R13 kept", test_en_o, 1);
    test_en_wr_i = 1; test_en_wdata_i = 0; step(); test_en_wr_i = 0;
    chk("R13 clear locked", test_en_o, 0);
    test_en_wr_i = 1; test_en_wdata_i = 1; step(); test_en_wr_i = 0;
    chk("R13 set blocked", test_en_o, 0);
    repeat (4) step();
    chk("R14 sticky", test_lock_o, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule